// File: doc/BRIEF.md
# Clock Enable Generator with Cascaded Ratio Dividers

This block produces every internal clock of a small controller as single-cycle enable pulses on one fast reference clock `clk`. Three source tick streams arrive as inputs: the main oscillator, the slow real-time oscillator and the PLL. A configuration port picks one of them as the master tick. The master tick then feeds a chain of three dividers. The CPU tier divides the master tick, the system bus tier divides the CPU tick, and the peripheral bus tier divides the system bus tick. Each tier accepts only a small, fixed set of ratios.

Two 16-bit prescalers, one for the timers and one for the baud-rate generator, divide the ungated peripheral bus tick. A separate selector produces the USB tick from the master tick, from every second master tick, or from an external 48 MHz tick input. Each derived output other than the CPU tick passes through its own firmware gate. All pulses are combinational in the cycle of the source tick that causes them. A configuration write takes effect from the cycle after the write edge.

Each divider is a two-state machine. In `ST_ALIGNED` the divider sits at a period boundary and uses the configured ratio directly. On an input tick with a ratio above 1 it moves to `ST_RUN`, where it counts ticks against the ratio it latched on leaving `ST_ALIGNED`. When the last tick of the period arrives it returns to `ST_ALIGNED`. With a ratio of 1 it stays in `ST_ALIGNED` and emits a pulse on every input tick.

Top module: `clk_enable_ctrl`

## Requirements
- R1: After reset the oscillator tick is the master source, every divider and prescaler has ratio 1, all gates are off, and with no ticks driven every output is 0.
- R2: Writing address 0 with value 0, 1 or 2 selects the oscillator, the real-time tick or the PLL tick as `master_en`. Value 3 is ignored.
- R3: Writing address 1 with codes 0 to 5 sets the CPU ratio to 1, 2, 4, 8, 16 or 1024 respectively. `cpu_en` pulses on the last master tick of each period.
- R4: CPU ratio codes 6 and 7 are ignored, and the previous ratio stays in effect.
- R5: Writing address 2 with codes 0, 1 or 2 sets the system bus ratio to 1, 2 or 4 CPU ticks. Code 3 is ignored.
- R6: Writing address 3 with codes 0 to 3 sets the peripheral bus ratio to 1, 2, 4 or 8 system bus ticks. The ungated system bus tick is the one that is divided.
- R7: Writing a 16-bit value P to address 4 (timer) or address 5 (baud) gives one output pulse per P+1 ungated peripheral bus ticks.
- R8: Address 6 holds the gates: bit 0 system bus, bit 1 peripheral bus, bit 2 timer, bit 3 baud, bit 4 USB. A cleared bit holds its output at 0 and does not disturb the counting behind it.
- R9: Writing address 7 with 0 selects the master tick for USB. Value 1 selects every second master tick, counted from reset. Value 2 selects `usb_ext_tick`. Value 3 is ignored.
- R10: A ratio written in the middle of a divided period does not change that period. The new ratio applies from the next period boundary onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Main oscillator tick |
| rtc_tick | input | 1 | Real-time oscillator tick |
| pll_tick | input | 1 | PLL tick |
| usb_ext_tick | input | 1 | External 48 MHz tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| master_en | output | 1 | Selected master tick |
| cpu_en | output | 1 | CPU tick (never gated) |
| bus_en | output | 1 | Gated system bus tick |
| pbus_en | output | 1 | Gated peripheral bus tick |
| tim_en | output | 1 | Gated timer prescaler tick |
| baud_en | output | 1 | Gated baud prescaler tick |
| usb_en | output | 1 | Gated USB tick |

## Verification
The embedded properties check, on every cycle, that each tier pulses only together with the tier that feeds it. They also check that a divider in `ST_RUN` keeps its counter inside the latched period and never changes that latched ratio, and that the stored source, CPU, bus and USB codes never take an illegal value. The exact pulse count for each ratio code, the rejection of illegal codes at the outputs, gate independence from counting and the deferred ratio change are shown only by the bench's windows. In those windows the bench counts output pulses and compares them with counts derived from the ratio tables.

// File: rtl/clk_enable_pkg.sv
`timescale 1ns/1ps
package clk_enable_pkg;
    localparam int CPU_CW  = 10;
    localparam int BUS_CW  = 2;
    localparam int PBUS_CW = 3;
    localparam int PRE_W   = 16;
    localparam int GATE_N  = 5;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 16;

    localparam logic [ADDR_W-1:0] A_SRC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CPU  = 3'd1;
    localparam logic [ADDR_W-1:0] A_BUS  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PBUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_TIM  = 3'd4;
    localparam logic [ADDR_W-1:0] A_BAUD = 3'd5;
    localparam logic [ADDR_W-1:0] A_GATE = 3'd6;
    localparam logic [ADDR_W-1:0] A_USB  = 3'd7;

    localparam logic [1:0] SRC_OSC  = 2'd0;
    localparam logic [1:0] SRC_RTC  = 2'd1;
    localparam logic [1:0] SRC_PLL  = 2'd2;
    localparam logic [1:0] USB_MST  = 2'd0;
    localparam logic [1:0] USB_HALF = 2'd1;
    localparam logic [1:0] USB_EXT  = 2'd2;

    typedef enum logic {ST_ALIGNED, ST_RUN} div_phase_e;

    function automatic logic [CPU_CW-1:0] cpu_last_f(input logic [2:0] code);
        logic [CPU_CW-1:0] r;
        case (code)
            3'd0:    r = CPU_CW'(0);
            3'd1:    r = CPU_CW'(1);
            3'd2:    r = CPU_CW'(3);
            3'd3:    r = CPU_CW'(7);
            3'd4:    r = CPU_CW'(15);
            default: r = CPU_CW'(1023);
        endcase
        return r;
    endfunction

    function automatic logic [BUS_CW-1:0] bus_last_f(input logic [1:0] code);
        logic [BUS_CW-1:0] r;
        case (code)
            2'd0:    r = BUS_CW'(0);
            2'd1:    r = BUS_CW'(1);
            default: r = BUS_CW'(3);
        endcase
        return r;
    endfunction

    function automatic logic [PBUS_CW-1:0] pbus_last_f(input logic [1:0] code);
        return PBUS_CW'((1 << code) - 1);
    endfunction
endpackage

// File: rtl/clk_rate_div.sv
`timescale 1ns/1ps
module clk_rate_div
    import clk_enable_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_tick,
    input  logic [CW-1:0] last_i,
    output logic          out_tick
);
    div_phase_e    st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;
    logic [CW-1:0] eff_last;

    // state register: ratio is latched only when a period starts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_ALIGNED;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (in_tick) begin
            unique case (st_q)
                ST_ALIGNED: begin
                    last_q <= last_i;
                    if (last_i != '0) begin
                        cnt_q <= CW'(1);
                        st_q  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == last_q) begin
                        cnt_q <= '0;
                        st_q  <= ST_ALIGNED;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    // output process
    always_comb begin
        unique case (st_q)
            ST_ALIGNED: eff_last = last_i;
            ST_RUN:     eff_last = last_q;
        endcase
        out_tick = in_tick && (cnt_q == eff_last);
    end

    p_aligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ALIGNED) |-> (cnt_q == '0));
    p_cnt_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q != '0 && cnt_q <= last_q));
    p_ratio_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |=> $stable(last_q));
endmodule

// File: rtl/clk_enable_cfg.sv
`timescale 1ns/1ps
module clk_enable_cfg
    import clk_enable_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [1:0]         src_sel,
    output logic [CPU_CW-1:0]  cpu_last,
    output logic [BUS_CW-1:0]  bus_last,
    output logic [PBUS_CW-1:0] pbus_last,
    output logic [PRE_W-1:0]   tim_last,
    output logic [PRE_W-1:0]   baud_last,
    output logic [GATE_N-1:0]  gates,
    output logic [1:0]         usb_sel
);
    logic [2:0] cpu_code_q;
    logic [1:0] bus_code_q, pbus_code_q, src_q, usb_q;
    logic [PRE_W-1:0]  tim_q, baud_q;
    logic [GATE_N-1:0] gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q       <= SRC_OSC;
            cpu_code_q  <= '0;
            bus_code_q  <= '0;
            pbus_code_q <= '0;
            tim_q       <= '0;
            baud_q      <= '0;
            gate_q      <= '0;
            usb_q       <= USB_MST;
        end else if (we) begin
            unique case (addr)
                A_SRC:  if (wdata[1:0] != 2'd3) src_q <= wdata[1:0];
                A_CPU:  if (wdata[2:0] <= 3'd5) cpu_code_q <= wdata[2:0];
                A_BUS:  if (wdata[1:0] != 2'd3) bus_code_q <= wdata[1:0];
                A_PBUS: pbus_code_q <= wdata[1:0];
                A_TIM:  tim_q <= wdata;
                A_BAUD: baud_q <= wdata;
                A_GATE: gate_q <= wdata[GATE_N-1:0];
                A_USB:  if (wdata[1:0] != 2'd3) usb_q <= wdata[1:0];
            endcase
        end
    end

    assign src_sel   = src_q;
    assign cpu_last  = cpu_last_f(cpu_code_q);
    assign bus_last  = bus_last_f(bus_code_q);
    assign pbus_last = pbus_last_f(pbus_code_q);
    assign tim_last  = tim_q;
    assign baud_last = baud_q;
    assign gates     = gate_q;
    assign usb_sel   = usb_q;

    p_src_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_q != 2'd3);
    p_cpu_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_code_q <= 3'd5);
    p_bus_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_code_q != 2'd3);
    p_usb_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        usb_q != 2'd3);
endmodule

// File: rtl/clk_enable_ctrl.sv
`timescale 1ns/1ps
module clk_enable_ctrl
    import clk_enable_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              rtc_tick,
    input  logic              pll_tick,
    input  logic              usb_ext_tick,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              master_en,
    output logic              cpu_en,
    output logic              bus_en,
    output logic              pbus_en,
    output logic              tim_en,
    output logic              baud_en,
    output logic              usb_en
);
    localparam int N_PRE = 2;

    logic [1:0]         src_sel, usb_sel;
    logic [CPU_CW-1:0]  cpu_last;
    logic [BUS_CW-1:0]  bus_last;
    logic [PBUS_CW-1:0] pbus_last;
    logic [PRE_W-1:0]   tim_last, baud_last;
    logic [GATE_N-1:0]  gates;
    logic               master_raw, cpu_raw, bus_raw, pbus_raw, usb_raw, half_q;
    logic [PRE_W-1:0]   pre_last [N_PRE];
    logic [N_PRE-1:0]   pre_out;

    clk_enable_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .src_sel(src_sel), .cpu_last(cpu_last), .bus_last(bus_last),
        .pbus_last(pbus_last), .tim_last(tim_last), .baud_last(baud_last),
        .gates(gates), .usb_sel(usb_sel)
    );

    always_comb begin
        case (src_sel)
            SRC_OSC: master_raw = osc_tick;
            SRC_RTC: master_raw = rtc_tick;
            SRC_PLL: master_raw = pll_tick;
            default: master_raw = 1'b0;
        endcase
    end

    clk_rate_div #(.CW(CPU_CW)) u_cpu (
        .clk(clk), .rst_n(rst_n), .in_tick(master_raw), .last_i(cpu_last), .out_tick(cpu_raw));
    clk_rate_div #(.CW(BUS_CW)) u_bus (
        .clk(clk), .rst_n(rst_n), .in_tick(cpu_raw), .last_i(bus_last), .out_tick(bus_raw));
    clk_rate_div #(.CW(PBUS_CW)) u_pbus (
        .clk(clk), .rst_n(rst_n), .in_tick(bus_raw), .last_i(pbus_last), .out_tick(pbus_raw));

    assign pre_last[0] = tim_last;
    assign pre_last[1] = baud_last;

    for (genvar g = 0; g < N_PRE; g++) begin : g_pre
        clk_rate_div #(.CW(PRE_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .in_tick(pbus_raw), .last_i(pre_last[g]),
            .out_tick(pre_out[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          half_q <= 1'b0;
        else if (master_raw) half_q <= ~half_q;
    end

    always_comb begin
        case (usb_sel)
            USB_MST:  usb_raw = master_raw;
            USB_HALF: usb_raw = master_raw & half_q;
            USB_EXT:  usb_raw = usb_ext_tick;
            default:  usb_raw = 1'b0;
        endcase
    end

    assign master_en = master_raw;
    assign cpu_en    = cpu_raw;
    assign bus_en    = bus_raw    & gates[0];
    assign pbus_en   = pbus_raw   & gates[1];
    assign tim_en    = pre_out[0] & gates[2];
    assign baud_en   = pre_out[1] & gates[3];
    assign usb_en    = usb_raw    & gates[4];

    p_cpu_sub_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_raw |-> master_raw);
    p_bus_sub_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_raw |-> cpu_raw);
    p_pbus_sub_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_raw |-> bus_raw);
    p_pre_sub_pbus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_out != '0) |-> pbus_raw);
    p_usb_half_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_sel == USB_HALF && usb_raw) |-> master_raw);
endmodule

// File: tb/sim_clk_enable_ctrl.sv
`timescale 1ns/1ps
module sim_clk_enable_ctrl;
    typedef struct {
        string tag;
        int    sel;
        int    exp;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 0, rtc_tick = 0, pll_tick = 0, usb_ext_tick = 0;
    logic cfg_we = 0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic master_en, cpu_en, bus_en, pbus_en, tim_en, baud_en, usb_en;

    int   cnt [7];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;
    exp_t sbq[$];
    event sb_ev;
    string names [7] = '{"master", "cpu", "bus", "pbus", "tim", "baud", "usb"};

    always #5 clk = ~clk;

    clk_enable_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rtc_tick(rtc_tick),
        .pll_tick(pll_tick), .usb_ext_tick(usb_ext_tick), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .master_en(master_en),
        .cpu_en(cpu_en), .bus_en(bus_en), .pbus_en(pbus_en), .tim_en(tim_en),
        .baud_en(baud_en), .usb_en(usb_en)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            cnt[0] = cnt[0] + int'(master_en);
            cnt[1] = cnt[1] + int'(cpu_en);
            cnt[2] = cnt[2] + int'(bus_en);
            cnt[3] = cnt[3] + int'(pbus_en);
            cnt[4] = cnt[4] + int'(tim_en);
            cnt[5] = cnt[5] + int'(baud_en);
            cnt[6] = cnt[6] + int'(usb_en);
        end
    end

    // monitor: pops expected items and compares with the counted pulses
    initial begin
        exp_t it;
        forever begin
            @(sb_ev);
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                n_chk++;
                if (cnt[it.sel] != it.exp) begin
                    n_err++;
                    $display("FAIL %s %s: actual=%0d expected=%0d",
                             it.tag, names[it.sel], cnt[it.sel], it.exp);
                end
            end
        end
    end

    task automatic clear_counts();
        for (int i = 0; i < 7; i++) cnt[i] = 0;
    endtask

    task automatic expect_cnt(input string tag, input int sel, input int exp);
        exp_t it;
        it.tag = tag;
        it.sel = sel;
        it.exp = exp;
        sbq.push_back(it);
    endtask

    task automatic flush();
        -> sb_ev;
        #1;
        clear_counts();
    endtask

    // mask bit 0 osc, 1 rtc, 2 pll, 3 external USB
    task automatic drive(input logic [3:0] mask, input int n);
        clear_counts();
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            osc_tick     = mask[0];
            rtc_tick     = mask[1];
            pll_tick     = mask[2];
            usb_ext_tick = mask[3];
        end
        @(posedge clk); #1;
        osc_tick = 0; rtc_tick = 0; pll_tick = 0; usb_ext_tick = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    initial begin
        #(1_000_000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int ratios [6] = '{1, 2, 4, 8, 16, 1024};
        clear_counts();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        drive(4'b0000, 5);
        for (int i = 0; i < 7; i++) expect_cnt("R1 idle", i, 0);
        flush();
        drive(4'b0001, 10);
        expect_cnt("R1 osc default", 0, 10);
        expect_cnt("R1 cpu ratio1", 1, 10);
        for (int i = 2; i < 7; i++) expect_cnt("R1 gates off", i, 0);
        flush();
        drive(4'b0110, 5);
        expect_cnt("R1 rtc/pll unselected", 0, 0);
        flush();

        // R2 source select
        wr(3'd0, 16'd1); drive(4'b0010, 6); expect_cnt("R2 rtc", 0, 6); flush();
        drive(4'b0001, 6); expect_cnt("R2 osc unselected", 0, 0); flush();
        wr(3'd0, 16'd2); drive(4'b0100, 6); expect_cnt("R2 pll", 0, 6); flush();
        wr(3'd0, 16'd3); drive(4'b0100, 4); expect_cnt("R2 code3 ignored", 0, 4); flush();
        wr(3'd0, 16'd0);

        // R8 gates on
        wr(3'd6, 16'h001F);
        drive(4'b0001, 8);
        for (int i = 2; i < 7; i++) expect_cnt("R8 gate on", i, 8);
        flush();

        // R3 cpu ratios
        for (int c = 0; c < 6; c++) begin
            wr(3'd1, 16'(c));
            drive(4'b0001, 3 * ratios[c]);
            expect_cnt("R3 cpu ratio", 1, 3);
            expect_cnt("R3 bus follows", 2, 3);
            flush();
        end

        // R4 illegal cpu codes
        wr(3'd1, 16'd0); drive(4'b0001, 5); expect_cnt("R4 back to 1", 1, 5); flush();
        wr(3'd1, 16'd6); drive(4'b0001, 4); expect_cnt("R4 code6 ignored", 1, 4); flush();
        wr(3'd1, 16'd7); drive(4'b0001, 3); expect_cnt("R4 code7 ignored", 1, 3); flush();

        // R5 bus ratios
        wr(3'd2, 16'd1); drive(4'b0001, 8);  expect_cnt("R5 bus /2", 2, 4); flush();
        wr(3'd2, 16'd2); drive(4'b0001, 16); expect_cnt("R5 bus /4", 2, 4); flush();
        wr(3'd2, 16'd3); drive(4'b0001, 8);  expect_cnt("R5 code3 ignored", 2, 2); flush();
        wr(3'd2, 16'd0); drive(4'b0001, 2);  expect_cnt("R5 bus /1", 2, 2); flush();

        // R6 peripheral bus ratios
        for (int c = 0; c < 4; c++) begin
            wr(3'd3, 16'(c));
            drive(4'b0001, 2 * (1 << c));
            expect_cnt("R6 pbus ratio", 3, 2);
            flush();
        end
        wr(3'd3, 16'd0);

        // R7 prescalers
        wr(3'd4, 16'd2); wr(3'd5, 16'd4);
        drive(4'b0001, 15);
        expect_cnt("R7 timer /3", 4, 5);
        expect_cnt("R7 baud /5", 5, 3);
        flush();

        // R8 gate off does not disturb counting
        wr(3'd6, 16'h001B);
        drive(4'b0001, 4);
        expect_cnt("R8 tim gated", 4, 0);
        expect_cnt("R8 pbus still on", 3, 4);
        flush();
        wr(3'd6, 16'h001F);
        drive(4'b0001, 2);
        expect_cnt("R8 count kept", 4, 1);
        flush();
        wr(3'd4, 16'd0); wr(3'd5, 16'd0);
        drive(4'b0001, 4);

        // R9 USB source
        wr(3'd7, 16'd1); drive(4'b0001, 8); expect_cnt("R9 half", 6, 4); flush();
        wr(3'd7, 16'd2); drive(4'b1000, 5);
        expect_cnt("R9 ext", 6, 5); expect_cnt("R9 ext master idle", 0, 0); flush();
        drive(4'b0001, 4); expect_cnt("R9 ext ignores master", 6, 0); flush();
        wr(3'd7, 16'd3); drive(4'b1000, 3); expect_cnt("R9 code3 ignored", 6, 3); flush();
        wr(3'd7, 16'd0);

        // R10 deferred ratio change
        wr(3'd1, 16'd2);
        drive(4'b0001, 2); expect_cnt("R10 mid period", 1, 0); flush();
        wr(3'd1, 16'd0);
        drive(4'b0001, 2); expect_cnt("R10 old period completes", 1, 1); flush();
        drive(4'b0001, 3); expect_cnt("R10 new ratio", 1, 3); flush();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule